// File: doc/BRIEF.md
# Serial receive holding register with sticky error flags

This block is the receive-side holding register of a serial port. A receive shift engine outside the block reports each finished character with a one-cycle strobe, the 9-bit character and two error indications (parity and framing). The block keeps the character and keeps a set of sticky error flags. It detects overruns by itself: a new character that lands before software has read the previous one through the low byte. It also holds a flag that reports lost arbitration from a two-wire bus mode.

Software sees a 16-bit word. The character sits in bits 8..0. Bits 10..9 are always zero. The flags sit above them: bit 11 is arbitration lost, bit 12 is overrun, bit 13 is framing, bit 14 is parity, and bit 15 is the error summary. A read strobe, qualified by a byte select, tells the block which byte software read. A write strobe with a single data bit lets software clear the arbitration flag.

Each flag has its own clearing rule. Parity and framing clear on a low-byte read. Overrun and the summary clear only when the port is switched off. The arbitration flag clears only when software writes a zero to it.

Top module: `rxb_holding_reg`

## Requirements
- R1: A cycle with `char_done`=1 loads `char_data` into bits 8..0 of `rd_word`, visible after that clock edge; bit 8 carries the ninth data bit. The load happens whatever the state of the port.
- R2: Bits 10..9 of `rd_word` always read 0.
- R3: Bit 15 (summary) reads 1 exactly when at least one of bits 14 (parity), 13 (framing) and 12 (overrun) is 1.
- R4: While the port is active, `char_done` with `char_perr`=1 sets bit 14, and `char_done` with `char_ferr`=1 sets bit 13. A low-byte read (`rd_en`=1, `rd_upper`=0) clears both flags. A high-byte read (`rd_en`=1, `rd_upper`=1) leaves them unchanged.
- R5: While the port is active, bit 12 sets when `char_done` arrives while the previous character is still unread. A character counts as unread until a low-byte read happens, and a low-byte read in the same cycle as the new character counts as a read. The new character still replaces bits 8..0. A low-byte read does not clear bit 12.
- R6: The port is active when `mode_sel` != 3'b000 and `rx_enable` = 1. While it is inactive, bits 15..12 read 0 after each edge, and error indications are ignored.
- R7: `arb_lost` sets bit 11. A write (`wr_en`=1) with `wr_arb_bit`=0 clears bit 11. A write with `wr_arb_bit`=1 leaves bit 11 unchanged. Bit 11 does not depend on whether the port is active.
- R8: When a set event and a clearing event for the same flag fall in the same cycle, the flag ends up set. This covers an error indication together with a low-byte read, and `arb_lost` together with a write of 0.
- R9: After reset, `rd_word` reads 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | Serial mode field; 3'b000 means the port is off |
| rx_enable | input | 1 | Receive enable |
| char_done | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | 9 | Received character |
| char_perr | input | 1 | Parity error for the character, valid with `char_done` |
| char_ferr | input | 1 | Framing error for the character, valid with `char_done` |
| arb_lost | input | 1 | Arbitration-lost event from the two-wire mode |
| rd_en | input | 1 | Software read strobe |
| rd_upper | input | 1 | Byte select for the read: 0 for the low byte, 1 for the high byte |
| wr_en | input | 1 | Software write strobe to the flag byte |
| wr_arb_bit | input | 1 | Value written to bit 11 |
| rd_word | output | 16 | Read view of the holding register |

## Verification
The assertions assume that every input has a known value once reset is released. They also assume that `char_perr` and `char_ferr` matter only in a cycle with `char_done` high. The bench keeps within these assumptions. It drives every input from one task at falling clock edges, and it holds all strobes low except in the cycle it is exercising. Mode and enable changes are applied between characters, so each edge checks exactly one combination of set, clear and disable events against the bench's own model.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // character and word geometry
  localparam int DATA_W  = 9;
  localparam int MODE_W  = 3;
  localparam int RSVD_W  = 2;
  localparam int WORD_W  = 16;

  // flag positions in the read word (software decodes these)
  localparam int POS_ARB = DATA_W + RSVD_W;   // 11
  localparam int POS_OVR = POS_ARB + 1;       // 12
  localparam int POS_FRM = POS_ARB + 2;       // 13
  localparam int POS_PAR = POS_ARB + 3;       // 14
  localparam int POS_SUM = POS_ARB + 4;       // 15

  // sticky error flag indices and the ones a low-byte read clears
  localparam int ERR_N   = 3;
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_OVR = 2;
  localparam logic [ERR_N-1:0] RD_CLR_MASK = 3'b011;

  // next value of a sticky flag: kill dominates, then set, then clear
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr, input logic kill);
    logic nxt;
    if (kill)      nxt = 1'b0;
    else if (set)  nxt = 1'b1;
    else if (clr)  nxt = 1'b0;
    else           nxt = cur;
    return nxt;
  endfunction

  // port considered active for error tracking
  function automatic logic rx_active(input logic [MODE_W-1:0] mode,
                                     input logic en);
    return (mode != '0) && en;
  endfunction

  // assemble the software view
  function automatic logic [WORD_W-1:0] pack_word(input logic [DATA_W-1:0] d,
                                                  input logic arb,
                                                  input logic [ERR_N-1:0] err);
    logic [WORD_W-1:0] w;
    w                    = '0;
    w[DATA_W-1:0]        = d;
    w[POS_ARB]           = arb;
    w[POS_OVR]           = err[ERR_OVR];
    w[POS_FRM]           = err[ERR_FRM];
    w[POS_PAR]           = err[ERR_PAR];
    w[POS_SUM]           = |err;
    return w;
  endfunction

endpackage

// File: rtl/rxb_char_latch.sv
module rxb_char_latch
  import rxb_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_done_i,
  input  logic [DW-1:0] char_data_i,
  input  logic          rd_lo_i,
  output logic [DW-1:0] data_o,
  output logic          unread_o,
  output logic          overrun_evt_o
);

  logic [DW-1:0] data_q;
  logic          unread_q;

  // a character arriving on top of an unread one, not rescued by a read this cycle
  assign overrun_evt_o = char_done_i & unread_q & ~rd_lo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      unread_q <= 1'b0;
    end else begin
      if (char_done_i) data_q <= char_data_i;
      unread_q <= sticky_next(unread_q, char_done_i, rd_lo_i, 1'b0);
    end
  end

  assign data_o   = data_q;
  assign unread_o = unread_q;

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    char_done_i |=> data_o == $past(char_data_i)); // R1

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done_i |=> $stable(data_o)); // R1

  AST_UNREAD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_i && !char_done_i |=> !unread_o); // R5

endmodule

// File: rtl/rxb_err_flag.sv
module rxb_err_flag #(
  parameter bit READ_CLEARS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic set_i,
  input  logic rd_lo_i,
  output logic flag_o
);

  logic flag_q;
  logic rd_clr;

  assign rd_clr = READ_CLEARS ? rd_lo_i : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= rxb_pkg::sticky_next(flag_q, set_i, rd_clr, !active_i);
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    active_i && set_i |=> flag_o); // R8

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !flag_o); // R6

  generate
    if (READ_CLEARS) begin : g_rd_clr
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        active_i && rd_lo_i && !set_i |=> !flag_o); // R4
    end else begin : g_rd_keep
      AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        active_i && flag_o |=> flag_o); // R5
    end
  endgenerate

endmodule

// File: rtl/rxb_arb_flag.sv
module rxb_arb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic flag_o
);

  logic flag_q;
  logic wr_clr;

  // only a written zero clears; a written one is a no-op
  assign wr_clr = wr_en_i & ~wr_val_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= rxb_pkg::sticky_next(flag_q, set_i, wr_clr, 1'b0);
  end

  assign flag_o = flag_q;

  AST_ARB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R8

  AST_ARB_W1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && wr_en_i && wr_val_i |=> flag_o); // R7

  AST_ARB_W0_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i && wr_en_i && !wr_val_i |=> !flag_o); // R7

endmodule

// File: rtl/rxb_holding_reg.sv
module rxb_holding_reg
  import rxb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              rx_enable,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              arb_lost,
  input  logic              rd_en,
  input  logic              rd_upper,
  input  logic              wr_en,
  input  logic              wr_arb_bit,
  output logic [WORD_W-1:0] rd_word
);

  // named internal events
  logic              port_active;
  logic              rd_lo;
  logic              overrun_evt;
  logic              unread;
  logic [DATA_W-1:0] data;
  logic [ERR_N-1:0]  err_set;
  logic [ERR_N-1:0]  err_q;
  logic              arb_q;

  assign port_active = rx_active(mode_sel, rx_enable);
  assign rd_lo       = rd_en & ~rd_upper;

  rxb_char_latch #(.DW(DATA_W)) u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_done_i   (char_done),
    .char_data_i   (char_data),
    .rd_lo_i       (rd_lo),
    .data_o        (data),
    .unread_o      (unread),
    .overrun_evt_o (overrun_evt)
  );

  assign err_set[ERR_PAR] = char_done & char_perr;
  assign err_set[ERR_FRM] = char_done & char_ferr;
  assign err_set[ERR_OVR] = overrun_evt;

  generate
    for (genvar gi = 0; gi < ERR_N; gi++) begin : g_err
      rxb_err_flag #(.READ_CLEARS(RD_CLR_MASK[gi])) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (port_active),
        .set_i    (err_set[gi]),
        .rd_lo_i  (rd_lo),
        .flag_o   (err_q[gi])
      );
    end
  endgenerate

  rxb_arb_flag u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (arb_lost),
    .wr_en_i  (wr_en),
    .wr_val_i (wr_arb_bit),
    .flag_o   (arb_q)
  );

  assign rd_word = pack_word(data, arb_q, err_q);

  AST_OFF_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !port_active |=> rd_word[POS_SUM:POS_OVR] == '0); // R6

  AST_OVERRUN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    port_active && char_done && unread && !rd_lo |=> rd_word[POS_OVR] && rd_word[POS_SUM]); // R5

  AST_HIGH_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    port_active && rd_en && rd_upper && !char_done |=> $stable(rd_word[POS_SUM:POS_OVR])); // R4

  AST_ARB_IGNORES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !port_active && !wr_en && !arb_lost |=> $stable(rd_word[POS_ARB])); // R7

endmodule

// File: tb/test_rxb_holding_reg.sv
module test_rxb_holding_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'b000;
  logic        rx_enable = 1'b0;
  logic        char_done = 1'b0;
  logic [8:0]  char_data = '0;
  logic        char_perr = 1'b0;
  logic        char_ferr = 1'b0;
  logic        arb_lost = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_upper = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_arb_bit = 1'b0;
  logic [15:0] rd_word;

  int checks = 0;
  int failures = 0;

  // model state, built from the requirements
  logic [8:0] m_data = '0;
  logic m_par = 0, m_frm = 0, m_ovr = 0, m_arb = 0, m_unread = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  rxb_holding_reg i_rxb_holding_reg (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx_enable(rx_enable),
    .char_done(char_done), .char_data(char_data), .char_perr(char_perr),
    .char_ferr(char_ferr), .arb_lost(arb_lost), .rd_en(rd_en),
    .rd_upper(rd_upper), .wr_en(wr_en), .wr_arb_bit(wr_arb_bit),
    .rd_word(rd_word)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: rd_word actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_word();
    // 15 sum, 14 parity, 13 framing, 12 overrun, 11 arb, 10..9 zero (R2)
    return {(m_par | m_frm | m_ovr), m_par, m_frm, m_ovr, m_arb, 2'b00, m_data};
  endfunction

  // driver: one clock of stimulus, model update, expected word into the queue
  task automatic cycle(input logic cd, input logic [8:0] d, input logic pe,
                       input logic fe, input logic ab, input logic rd,
                       input logic up, input logic we, input logic wv,
                       input string tag);
    logic act, ovr_ev;
    char_done = cd; char_data = d; char_perr = pe; char_ferr = fe;
    arb_lost = ab; rd_en = rd; rd_upper = up; wr_en = we; wr_arb_bit = wv;
    @(posedge clk);
    #1;
    act    = (mode_sel != 3'b000) && rx_enable;
    ovr_ev = cd && m_unread && !(rd && !up);
    if (!act) begin
      m_par = 0; m_frm = 0; m_ovr = 0;
    end else begin
      if (cd && pe) m_par = 1; else if (rd && !up) m_par = 0;
      if (cd && fe) m_frm = 1; else if (rd && !up) m_frm = 0;
      if (ovr_ev) m_ovr = 1;
    end
    if (cd) m_unread = 1; else if (rd && !up) m_unread = 0;
    if (cd) m_data = d;
    if (ab) m_arb = 1; else if (we && !wv) m_arb = 0;
    exp_q.push_back(model_word());
    tag_q.push_back(tag);
    @(negedge clk);
    char_done = 0; char_perr = 0; char_ferr = 0; arb_lost = 0;
    rd_en = 0; rd_upper = 0; wr_en = 0; wr_arb_bit = 0;
  endtask

  task automatic idle(input string tag);
    cycle(0, '0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic send(input logic [8:0] d, input logic pe, input logic fe, input string tag);
    cycle(1, d, pe, fe, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic read_lo(input string tag);
    cycle(0, '0, 0, 0, 0, 1, 0, 0, 0, tag);
  endtask
  task automatic read_hi(input string tag);
    cycle(0, '0, 0, 0, 0, 1, 1, 0, 0, tag);
  endtask
  task automatic write_arb(input logic v, input string tag);
    cycle(0, '0, 0, 0, 0, 0, 0, 1, v, tag);
  endtask

  // monitor: compare each expected word one half-cycle after its edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_word, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset value", rd_word, 16'h0000);
    rst_n = 1'b1;
    idle("R9 after reset");

    mode_sel = 3'b001; rx_enable = 1'b1;
    send(9'h1A5, 0, 0, "R1 ninth bit loaded");
    read_lo("R1 clean read");
    send(9'h05A, 1, 0, "R4 R3 parity sets");
    read_hi("R4 high read keeps parity");
    read_lo("R4 low read clears parity");
    send(9'h0FF, 0, 1, "R4 R3 framing sets");
    read_lo("R4 low read clears framing");
    send(9'h1FF, 1, 1, "R2 reserved zero, both errors");
    read_lo("R4 both cleared");

    send(9'h011, 0, 0, "R5 first char");
    send(9'h122, 0, 0, "R5 overrun, new data kept");
    read_lo("R5 low read keeps overrun");
    read_hi("R5 high read keeps overrun");
    send(9'h033, 0, 0, "R5 next char, overrun held");
    cycle(1, 9'h044, 0, 0, 0, 1, 0, 0, 0, "R5 read same cycle, no new overrun");
    cycle(1, 9'h055, 1, 0, 0, 1, 0, 0, 0, "R8 parity set beats read clear");

    rx_enable = 1'b0;
    idle("R6 receive off clears flags");
    send(9'h066, 1, 1, "R6 errors ignored while off, R1 data loads");
    rx_enable = 1'b1;
    read_lo("R6 re-enabled, clean");
    send(9'h077, 1, 0, "R6 active again");
    mode_sel = 3'b000;
    idle("R6 mode off clears flags");
    mode_sel = 3'b010;
    idle("R6 mode on, flags stay clear");

    cycle(0, '0, 0, 0, 1, 0, 0, 0, 0, "R7 arb set");
    write_arb(1, "R7 write one keeps arb");
    read_lo("R7 read keeps arb");
    write_arb(0, "R7 write zero clears arb");
    cycle(0, '0, 0, 0, 1, 0, 0, 1, 0, "R8 arb set beats write zero");
    rx_enable = 1'b0;
    idle("R7 arb unaffected by port off");
    write_arb(0, "R7 clear while port off");
    rx_enable = 1'b1;
    idle("R3 final quiet");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule